// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block holds the register state behind a four-channel digital potentiometer. Each channel has an active wiper code that drives the resistor network, a staging register for preloading a new code, and a nonvolatile copy that is restored on reset. Commands arrive already deframed: a 4-bit opcode, a target that is either one channel or every channel at once, and an 8-bit data byte. Accepted commands are carried out by a small sequencer that holds `busy` for the whole command. Nonvolatile store and reload operations keep it busy for a parameterised latency.

The wiper codes change in several ways. A command can write them directly. Staged codes can be copied across by a load command or by a falling edge on an external load pin. Codes can be doubled or halved in logarithmic steps, or restored from the nonvolatile copy by a command or by a low pulse on a reset pin. A shutdown flag per channel can be set and cleared without touching the codes. Two lock bits in a control register, and an active-low write-protect pin, stop changes to the wipers or to the nonvolatile copy. A third control bit is passed out to the bus framer as the burst-mode enable.

Top module: `dpot_regctl`

## Requirements
- R1: After the synchronous reset, every wiper reads 0x80, every shutdown flag is 0, `busy` and `burst_en` are 0, and the nonvolatile copy of every channel holds 0x80.
- R2: Opcode 1 writes the data byte into the wiper of the addressed channel. With `cmd_all`=1 it writes every wiper. It marks the addressed channels' staging registers clean.
- R3: Opcode 2 writes only the staging register of the target and leaves the wiper unchanged. Opcode 8 then copies the staging register into the wiper, for one channel or for all.
- R4: A copy from staging (opcode 8 or the load pin) changes only channels whose staging register was written by opcode 2 since its last copy, opcode 1 or reload. A copy leaves that channel clean again.
- R5: Opcode 6 doubles the wiper code: 0 becomes 1, and any code with bit 7 set becomes 0xFF. Opcode 7 shifts the code right by one, so 0 stays 0.
- R6: A falling edge on `load_n` while the block is idle copies every written staging register into its wiper. An edge that arrives while `busy` is 1 is dropped.
- R7: Opcode 15 sets the shutdown flags of the target when data bit 0 is 1 and clears them when it is 0. Wiper codes are left unchanged, and other commands still run while a channel is shut down.
- R8: Opcode 9 stores the target wipers into the nonvolatile copy. Opcode 14 reloads every wiper from that copy. Each of the two holds `busy` for NV_LAT+1 cycles.
- R9: A low pulse on `reload_n` reloads every wiper from the nonvolatile copy, in the same way as opcode 14.
- R10: Opcode 11 writes the control register: bit 0 locks the wipers, bit 1 locks the nonvolatile copy, and bit 3 is the burst enable. With the wiper lock set, opcodes 1, 6, 7, 8 and the load pin have no effect, while a reload from the nonvolatile copy still works.
- R11: With the nonvolatile lock set, opcode 9 has no effect, while opcode 1 still writes the wipers. The two locks act independently.
- R12: `wp_n` low applies both locks. A change of `wp_n` while `busy` is 1 takes effect only once the running command has completed.
- R13: `burst_en` follows control bit 3.
- R14: A command is accepted when `cmd_valid` and `cmd_ready` are both 1. `busy` is 1 on the next cycle, and `cmd_ready` is 0 whenever `busy` is 1. Commands other than store and reload keep `busy` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_all | input | 1 | Target every channel |
| cmd_chan | input | 2 | Target channel when `cmd_all` is 0 |
| cmd_data | input | 8 | Data byte |
| load_n | input | 1 | Asynchronous staging-to-wiper load pin, falling edge active |
| reload_n | input | 1 | Asynchronous reload pin, low pulse active |
| wp_n | input | 1 | Asynchronous write-protect pin, active low |
| busy | output | 1 | A command is in progress |
| wiper_flat | output | 32 | Wiper codes, channel i at bits [8i+7:8i] |
| shdn | output | 4 | Shutdown flag per channel |
| burst_en | output | 1 | Burst-mode enable for the bus framer |

## Verification
The bench checks that a load issued after an opcode 1 write leaves the wiper alone. A design without per-channel written-state tracking would overwrite that wiper with a stale staging value. It pulses the load pin and drops the write-protect pin in the middle of a long store. A design that sampled pins while busy would then change wipers halfway through a command, or would lose a store that began unprotected. The doubling and halving checks cover zero, bit-7-set and saturated codes, where a plain shift gives 0x00 or a wrapped value. The lock checks confirm that a reload still works under the wiper lock, and that each lock leaves the other register set writable.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_WR_WIPER = 4'd1,
        OP_WR_STAGE = 4'd2,
        OP_UP6      = 4'd6,
        OP_DN6      = 4'd7,
        OP_LOAD     = 4'd8,
        OP_STORE    = 4'd9,
        OP_CTRL     = 4'd11,
        OP_RELOAD   = 4'd14,
        OP_SHDN     = 4'd15
    } op_e;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_WR_WIPER,
        ACT_WR_STAGE,
        ACT_UP6,
        ACT_DN6,
        ACT_LOAD,
        ACT_RELOAD,
        ACT_SHDN_ON,
        ACT_SHDN_OFF
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_NVWAIT
    } state_e;

    typedef enum logic {
        NV_STORE,
        NV_RELOAD
    } nv_kind_e;

    typedef struct packed {
        logic burst;
        logic nv_lock;
        logic wiper_lock;
    } ctrl_t;

endpackage

// File: rtl/dpot_pin_sync.sv
module dpot_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic lvl_n,
    output logic fall
);
    // sh[0..STAGES-1] synchroniser, sh[STAGES] previous synchronised level
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], pin_n};
    end

    assign lvl_n = sh[STAGES-1];
    assign fall  = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/dpot_chan.sv
module dpot_chan
    import dpot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  act_e         act,
    input  logic         sel,
    input  logic [W-1:0] data,
    input  logic [W-1:0] nv_val,
    output logic [W-1:0] wiper,
    output logic         shdn
);
    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    logic [W-1:0] wiper_q, stage_q, up_code;
    logic         dirty_q, shdn_q;

    always_comb begin
        if (wiper_q == '0)         up_code = W'(1);
        else if (wiper_q[W-1])     up_code = '1;
        else                       up_code = wiper_q << 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper_q <= MID;
            stage_q <= MID;
            dirty_q <= 1'b0;
            shdn_q  <= 1'b0;
        end else if (sel) begin
            unique case (act)
                ACT_WR_WIPER: begin wiper_q <= data; dirty_q <= 1'b0; end
                ACT_WR_STAGE: begin stage_q <= data; dirty_q <= 1'b1; end
                ACT_UP6:      wiper_q <= up_code;
                ACT_DN6:      wiper_q <= wiper_q >> 1;
                ACT_LOAD: begin
                    if (dirty_q) wiper_q <= stage_q;
                    dirty_q <= 1'b0;
                end
                ACT_RELOAD:   begin wiper_q <= nv_val; dirty_q <= 1'b0; end
                ACT_SHDN_ON:  shdn_q <= 1'b1;
                ACT_SHDN_OFF: shdn_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign wiper = wiper_q;
    assign shdn  = shdn_q;
endmodule

// File: rtl/dpot_nvm.sv
module dpot_nvm #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           store,
    input  logic [N-1:0]   mask,
    input  logic [N*W-1:0] wiper_in,
    output logic [N*W-1:0] nv_out
);
    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst)                 mem[i] <= MID;
            else if (store && mask[i]) mem[i] <= wiper_in[i*W +: W];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_out
        assign nv_out[g*W +: W] = mem[g];
    end
endmodule

// File: rtl/dpot_seq.sv
module dpot_seq
    import dpot_pkg::*;
#(
    parameter int N      = 4,
    parameter int W      = 8,
    parameter int NV_LAT = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [3:0]           cmd_op,
    input  logic                 cmd_all,
    input  logic [$clog2(N)-1:0] cmd_chan,
    input  logic [W-1:0]         cmd_data,
    input  logic                 load_fall,
    input  logic                 rpin_fall,
    input  logic                 wp_lvl_n,
    output logic                 cmd_ready,
    output logic                 busy,
    output act_e                 act,
    output logic [N-1:0]         act_mask,
    output logic [W-1:0]         act_data,
    output logic                 nv_store,
    output logic [N-1:0]         nv_mask,
    output logic                 wp_eff,
    output logic                 burst_en
);
    localparam int CHW = $clog2(N);
    localparam int CW  = $clog2(NV_LAT + 1);

    state_e          state_q;
    nv_kind_e        kind_q;
    logic [CW-1:0]   cnt_q;
    op_e             op_q;
    logic            all_q;
    logic [CHW-1:0]  chan_q;
    logic [W-1:0]    data_q;
    ctrl_t           ctrl_q;
    logic            wp_q, rst_pend_q;
    logic            go_reset, accept, prot_w, prot_nv;
    logic [N-1:0]    sel;

    assign prot_w    = ctrl_q.wiper_lock | wp_q;
    assign prot_nv   = ctrl_q.nv_lock | wp_q;
    assign go_reset  = rpin_fall | rst_pend_q;
    assign cmd_ready = (state_q == ST_IDLE) && !go_reset;
    assign accept    = cmd_valid && cmd_ready;
    assign busy      = (state_q != ST_IDLE);
    assign wp_eff    = wp_q;
    assign burst_en  = ctrl_q.burst;

    always_comb begin
        for (int i = 0; i < N; i++) sel[i] = all_q || (chan_q == CHW'(i));
    end

    always_comb begin
        act      = ACT_NONE;
        act_mask = '0;
        act_data = data_q;
        nv_store = 1'b0;
        nv_mask  = sel;
        unique case (state_q)
            ST_IDLE: begin
                if (!go_reset && load_fall && !prot_w) begin
                    act      = ACT_LOAD;
                    act_mask = '1;
                end
            end
            ST_EXEC: begin
                act_mask = sel;
                unique case (op_q)
                    OP_WR_WIPER: if (!prot_w) act = ACT_WR_WIPER;
                    OP_WR_STAGE: act = ACT_WR_STAGE;
                    OP_UP6:      if (!prot_w) act = ACT_UP6;
                    OP_DN6:      if (!prot_w) act = ACT_DN6;
                    OP_LOAD:     if (!prot_w) act = ACT_LOAD;
                    OP_SHDN:     act = data_q[0] ? ACT_SHDN_ON : ACT_SHDN_OFF;
                    default:     act = ACT_NONE;
                endcase
            end
            ST_NVWAIT: begin
                if (cnt_q == '0) begin
                    if (kind_q == NV_RELOAD) begin
                        act      = ACT_RELOAD;
                        act_mask = '1;
                    end else begin
                        nv_store = !prot_nv;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            kind_q     <= NV_STORE;
            cnt_q      <= '0;
            op_q       <= OP_NOP;
            all_q      <= 1'b0;
            chan_q     <= '0;
            data_q     <= '0;
            ctrl_q     <= '0;
            wp_q       <= 1'b0;
            rst_pend_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    wp_q <= !wp_lvl_n;
                    if (go_reset) begin
                        state_q    <= ST_NVWAIT;
                        kind_q     <= NV_RELOAD;
                        cnt_q      <= CW'(NV_LAT - 1);
                        rst_pend_q <= 1'b0;
                    end else if (accept) begin
                        state_q <= ST_EXEC;
                        op_q    <= op_e'(cmd_op);
                        all_q   <= cmd_all;
                        chan_q  <= cmd_chan;
                        data_q  <= cmd_data;
                    end
                end
                ST_EXEC: begin
                    unique case (op_q)
                        OP_STORE: begin
                            state_q <= ST_NVWAIT;
                            kind_q  <= NV_STORE;
                            cnt_q   <= CW'(NV_LAT - 1);
                        end
                        OP_RELOAD: begin
                            state_q <= ST_NVWAIT;
                            kind_q  <= NV_RELOAD;
                            cnt_q   <= CW'(NV_LAT - 1);
                        end
                        OP_CTRL: begin
                            ctrl_q  <= '{burst: data_q[3], nv_lock: data_q[1],
                                         wiper_lock: data_q[0]};
                            state_q <= ST_IDLE;
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
                ST_NVWAIT: begin
                    if (cnt_q == '0) state_q <= ST_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (state_q != ST_IDLE && rpin_fall) rst_pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/dpot_regctl.sv
module dpot_regctl
    import dpot_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int CODE_W      = 8,
    parameter int NV_LAT      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [3:0]              cmd_op,
    input  logic                    cmd_all,
    input  logic [$clog2(N_CH)-1:0] cmd_chan,
    input  logic [CODE_W-1:0]       cmd_data,
    input  logic                    load_n,
    input  logic                    reload_n,
    input  logic                    wp_n,
    output logic                    busy,
    output logic [N_CH*CODE_W-1:0]  wiper_flat,
    output logic [N_CH-1:0]         shdn,
    output logic                    burst_en
);
    logic                    load_fall, rpin_fall, wp_lvl_n;
    logic                    load_lvl_unused, rpin_lvl_unused, wp_fall_unused;
    act_e                    act;
    logic [N_CH-1:0]         act_mask, nv_mask;
    logic [CODE_W-1:0]       act_data;
    logic                    nv_store, wp_eff;
    logic [N_CH*CODE_W-1:0]  nv_flat;

    dpot_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_load (
        .clk(clk), .rst(rst), .pin_n(load_n), .lvl_n(load_lvl_unused), .fall(load_fall));
    dpot_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_rpin (
        .clk(clk), .rst(rst), .pin_n(reload_n), .lvl_n(rpin_lvl_unused), .fall(rpin_fall));
    dpot_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_wp (
        .clk(clk), .rst(rst), .pin_n(wp_n), .lvl_n(wp_lvl_n), .fall(wp_fall_unused));

    dpot_seq #(.N(N_CH), .W(CODE_W), .NV_LAT(NV_LAT)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_all(cmd_all),
        .cmd_chan(cmd_chan), .cmd_data(cmd_data),
        .load_fall(load_fall), .rpin_fall(rpin_fall), .wp_lvl_n(wp_lvl_n),
        .cmd_ready(cmd_ready), .busy(busy),
        .act(act), .act_mask(act_mask), .act_data(act_data),
        .nv_store(nv_store), .nv_mask(nv_mask),
        .wp_eff(wp_eff), .burst_en(burst_en));

    dpot_nvm #(.N(N_CH), .W(CODE_W)) u_nvm (
        .clk(clk), .rst(rst), .store(nv_store), .mask(nv_mask),
        .wiper_in(wiper_flat), .nv_out(nv_flat));

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        dpot_chan #(.W(CODE_W)) u_chan (
            .clk(clk), .rst(rst), .act(act), .sel(act_mask[g]),
            .data(act_data), .nv_val(nv_flat[g*CODE_W +: CODE_W]),
            .wiper(wiper_flat[g*CODE_W +: CODE_W]), .shdn(shdn[g]));
    end
endmodule

// File: rtl/dpot_regctl_chk.sv
module dpot_regctl_chk #(
    parameter int N_CH   = 4,
    parameter int CODE_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cmd_valid,
    input logic                   cmd_ready,
    input logic                   busy,
    input logic                   load_fall,
    input logic                   rpin_fall,
    input logic                   wp_eff,
    input logic [N_CH*CODE_W-1:0] wiper_flat,
    input logic [N_CH-1:0]        shdn
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wiper_flat == {N_CH{MID}} && shdn == '0 && !busy));

    a_r14_ready_low_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cmd_ready);

    a_r14_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> busy);

    a_r6_idle_wipers_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load_fall && !rpin_fall) |=> $stable(wiper_flat));

    a_r7_shdn_keeps_codes: assert property (@(posedge clk) disable iff (rst)
        (shdn != $past(shdn)) |-> (wiper_flat == $past(wiper_flat)));

    a_r12_wp_frozen_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(wp_eff));
endmodule

bind dpot_regctl dpot_regctl_chk #(.N_CH(N_CH), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .busy(busy), .load_fall(load_fall), .rpin_fall(rpin_fall), .wp_eff(wp_eff),
    .wiper_flat(wiper_flat), .shdn(shdn));

// File: tb/dpot_regctl_tb.sv
module dpot_regctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV_LAT     = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0, cmd_ready, cmd_all = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [1:0] cmd_chan = '0;
    logic [7:0] cmd_data = '0;
    logic       load_n = 1'b1, reload_n = 1'b1, wp_n = 1'b1;
    logic       busy, burst_en;
    logic [31:0] wiper_flat;
    logic [3:0]  shdn;

    int checks = 0, fails = 0;
    logic [7:0] ew [4];
    logic [7:0] env [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpot_regctl #(.NV_LAT(NV_LAT)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_all(cmd_all), .cmd_chan(cmd_chan), .cmd_data(cmd_data),
        .load_n(load_n), .reload_n(reload_n), .wp_n(wp_n), .busy(busy),
        .wiper_flat(wiper_flat), .shdn(shdn), .burst_en(burst_en));

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_wipers(string req);
        for (int i = 0; i < 4; i++) chk(req, 16'(wiper_flat[i*8 +: 8]), 16'(ew[i]));
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic send(input logic [3:0] op, input logic all, input logic [1:0] ch,
                        input logic [7:0] d, input bit wait_done);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_all = all; cmd_chan = ch; cmd_data = d; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (wait_done) wait_idle();
    endtask

    task automatic set_all(input logic [7:0] v);
        send(4'd1, 1'b1, 2'd0, v, 1'b1);
        for (int i = 0; i < 4; i++) ew[i] = v;
    endtask

    task automatic pulse_load();
        load_n = 1'b0; repeat (2) @(negedge clk); load_n = 1'b1; repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin ew[i] = 8'h80; env[i] = 8'h80; end
        chk_wipers("R1 wipers");
        chk("R1 shdn", 16'(shdn), 16'h0);
        chk("R1 busy", 16'(busy), 16'h0);
        chk("R1 burst", 16'(burst_en), 16'h0);
    endtask

    task automatic t_busy();
        int n;
        send(4'd0, 1'b0, 2'd0, 8'h00, 1'b0);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R14 one-cycle busy", 16'(n), 16'd1);
        chk("R14 ready when idle", 16'(cmd_ready), 16'd1);
    endtask

    task automatic t_write_wiper();
        send(4'd1, 1'b0, 2'd2, 8'h5A, 1'b1); ew[2] = 8'h5A;
        chk_wipers("R2 single channel");
        set_all(8'h11);
        chk_wipers("R2 all channels");
    endtask

    task automatic t_stage_load();
        send(4'd2, 1'b0, 2'd1, 8'h44, 1'b1);
        chk_wipers("R3 staging write leaves wiper");
        send(4'd8, 1'b0, 2'd1, 8'h00, 1'b1); ew[1] = 8'h44;
        chk_wipers("R3 load one channel");
        send(4'd2, 1'b0, 2'd0, 8'h22, 1'b1);
        send(4'd2, 1'b0, 2'd3, 8'h33, 1'b1);
        send(4'd8, 1'b1, 2'd0, 8'h00, 1'b1); ew[0] = 8'h22; ew[3] = 8'h33;
        chk_wipers("R3 load all channels");
        send(4'd2, 1'b0, 2'd0, 8'h66, 1'b1);
        send(4'd1, 1'b0, 2'd0, 8'h99, 1'b1); ew[0] = 8'h99;
        send(4'd8, 1'b1, 2'd0, 8'h00, 1'b1);
        chk_wipers("R4 direct write makes staging clean");
        send(4'd1, 1'b0, 2'd1, 8'h0F, 1'b1); ew[1] = 8'h0F;
        send(4'd8, 1'b1, 2'd0, 8'h00, 1'b1);
        chk_wipers("R4 second load changes nothing");
    endtask

    task automatic step(input logic [3:0] op, input logic [7:0] start, input logic [7:0] exp,
                        input string req);
        send(4'd1, 1'b0, 2'd0, start, 1'b1);
        send(op, 1'b0, 2'd0, 8'h00, 1'b1);
        chk(req, 16'(wiper_flat[7:0]), 16'(exp));
    endtask

    task automatic t_log();
        step(4'd6, 8'h00, 8'h01, "R5 up from zero");
        step(4'd6, 8'h01, 8'h02, "R5 up doubles");
        step(4'd6, 8'h40, 8'h80, "R5 up to top bit");
        step(4'd6, 8'h81, 8'hFF, "R5 up saturates");
        step(4'd6, 8'hFF, 8'hFF, "R5 up at full");
        step(4'd7, 8'hFF, 8'h7F, "R5 down halves");
        step(4'd7, 8'h01, 8'h00, "R5 down to zero");
        step(4'd7, 8'h00, 8'h00, "R5 down at zero");
        set_all(8'h20);
        send(4'd6, 1'b1, 2'd0, 8'h00, 1'b1);
        for (int i = 0; i < 4; i++) ew[i] = 8'h40;
        chk_wipers("R5 up all channels");
    endtask

    task automatic t_hw_load();
        send(4'd2, 1'b0, 2'd2, 8'h77, 1'b1);
        pulse_load(); wait_idle(); ew[2] = 8'h77;
        chk_wipers("R6 load pin while idle");
        send(4'd2, 1'b0, 2'd3, 8'h66, 1'b1);
        send(4'd9, 1'b0, 2'd0, 8'h00, 1'b0); env[0] = ew[0];
        pulse_load(); wait_idle();
        chk_wipers("R6 load pin ignored while busy");
    endtask

    task automatic t_shutdown();
        send(4'd15, 1'b0, 2'd1, 8'h01, 1'b1);
        chk("R7 shutdown one", 16'(shdn), 16'h2);
        chk_wipers("R7 codes kept");
        send(4'd1, 1'b0, 2'd1, 8'h12, 1'b1); ew[1] = 8'h12;
        chk_wipers("R7 write during shutdown");
        send(4'd15, 1'b1, 2'd0, 8'h01, 1'b1);
        chk("R7 shutdown all", 16'(shdn), 16'hF);
        send(4'd15, 1'b1, 2'd0, 8'h00, 1'b1);
        chk("R7 exit all", 16'(shdn), 16'h0);
        chk_wipers("R7 codes kept on exit");
    endtask

    task automatic t_nv();
        int n;
        send(4'd1, 1'b0, 2'd3, 8'hA5, 1'b1); ew[3] = 8'hA5;
        send(4'd9, 1'b1, 2'd0, 8'h00, 1'b1);
        for (int i = 0; i < 4; i++) env[i] = ew[i];
        set_all(8'h03);
        send(4'd14, 1'b0, 2'd0, 8'h00, 1'b0);
        n = 1;
        while (busy) begin n++; @(negedge clk); end
        n--;
        chk("R8 reload busy length", 16'(n), 16'(NV_LAT + 1));
        for (int i = 0; i < 4; i++) ew[i] = env[i];
        chk_wipers("R8 reload restores stored codes");
        set_all(8'h07);
        reload_n = 1'b0; repeat (2) @(negedge clk); reload_n = 1'b1;
        repeat (4) @(negedge clk); wait_idle();
        for (int i = 0; i < 4; i++) ew[i] = env[i];
        chk_wipers("R9 reload pin");
    endtask

    task automatic t_locks();
        send(4'd11, 1'b0, 2'd0, 8'h01, 1'b1);
        send(4'd1, 1'b0, 2'd0, 8'hAA, 1'b1);
        send(4'd6, 1'b1, 2'd0, 8'h00, 1'b1);
        send(4'd7, 1'b1, 2'd0, 8'h00, 1'b1);
        chk_wipers("R10 wiper lock blocks write and steps");
        send(4'd2, 1'b0, 2'd1, 8'h55, 1'b1);
        send(4'd8, 1'b1, 2'd0, 8'h00, 1'b1);
        pulse_load(); wait_idle();
        chk_wipers("R10 wiper lock blocks loads");
        send(4'd11, 1'b0, 2'd0, 8'h00, 1'b1);
        set_all(8'h30);
        send(4'd11, 1'b0, 2'd0, 8'h01, 1'b1);
        send(4'd14, 1'b0, 2'd0, 8'h00, 1'b1);
        for (int i = 0; i < 4; i++) ew[i] = env[i];
        chk_wipers("R10 reload allowed under wiper lock");
        send(4'd11, 1'b0, 2'd0, 8'h02, 1'b1);
        set_all(8'h3C);
        chk_wipers("R11 wiper writable under nv lock");
        send(4'd9, 1'b1, 2'd0, 8'h00, 1'b1);
        send(4'd14, 1'b0, 2'd0, 8'h00, 1'b1);
        for (int i = 0; i < 4; i++) ew[i] = env[i];
        chk_wipers("R11 store blocked under nv lock");
        send(4'd11, 1'b0, 2'd0, 8'h08, 1'b1);
        chk("R13 burst on", 16'(burst_en), 16'h1);
        send(4'd11, 1'b0, 2'd0, 8'h00, 1'b1);
        chk("R13 burst off", 16'(burst_en), 16'h0);
    endtask

    task automatic t_wp_pin();
        set_all(8'hC0);
        send(4'd9, 1'b1, 2'd0, 8'h00, 1'b0);
        wp_n = 1'b0;
        wait_idle();
        for (int i = 0; i < 4; i++) env[i] = 8'hC0;
        repeat (2) @(negedge clk);
        send(4'd1, 1'b1, 2'd0, 8'h01, 1'b1);
        chk_wipers("R12 pin lock blocks write");
        wp_n = 1'b1; repeat (4) @(negedge clk);
        set_all(8'h01);
        chk_wipers("R12 write after pin release");
        send(4'd14, 1'b0, 2'd0, 8'h00, 1'b1);
        for (int i = 0; i < 4; i++) ew[i] = 8'hC0;
        chk_wipers("R12 store begun unprotected completes");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_busy();
        t_write_wiper();
        t_stage_load();
        t_log();
        t_hw_load();
        t_shutdown();
        t_nv();
        t_locks();
        t_wp_pin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule